// File: doc/BRIEF.md
# Dual-Delay Time-to-Digital Recovery

This block turns the timing of two complementary delay-line outputs into a signed digital sample. In every sample-clock period, one delay chain (the positive path) gets longer as the analogue input rises and the other (the negative path) gets shorter. Their sum is designed to stay constant. The block counts a fast reference clock from each sample-clock rising edge up to the rising edge of each delayed pulse. This gives two delay codes, DP and DN.

The recovered sample comes from the difference of the two codes. A calibrated offset difference is removed, and the result is scaled by a programmed reciprocal of the slope constant, followed by a fixed right shift. Two flags go out with the sample. One warns that the two codes no longer add up to the expected constant. The other warns that a pulse edge never arrived within its period.

All inputs are sampled by the fast clock through equal-depth synchronisers. The calibration inputs are held static while the block runs.

Top module: `ddtdc_top`

## Requirements
- R1: While reset is held and after its release, `valid_o`, `err_miss_o` and `err_sum_o` are low and `sample_o` is zero until the first sample is produced.
- R2: Each delay code equals the number of fast-clock edges between the rising edge of `smp_clk_i` and the rising edge of the matching pulse input. Falling edges carry no meaning.
- R3: The sample equals floor((DP − DN − `cfg_ofs_diff_i`) × `cfg_recip_i` / 2^(SHIFT+1)). It is two's complement, with SHIFT = 12 by default.
- R4: Exactly one sample is emitted per sample-clock period. Further rising edges on a pulse input within the same period are ignored.
- R5: `valid_o` is high for exactly one cycle. It rises in the cycle after the fourth clock edge following the edge that first samples the later of the two pulses high.
- R6: `err_sum_o` is high with a sample when |DP + DN − `cfg_sum_i`| > `cfg_tol_i`. A deviation equal to the tolerance does not flag.
- R7: If the counter reaches its maximum 2^CNT_W − 1 before a pulse edge arrives, the sample is emitted at that point. The missing code is taken as 2^CNT_W − 1, and `err_miss_o` is high.
- R8: If the next sample-clock edge comes before a pulse edge, the open period is emitted with the missing code set to 2^CNT_W − 1 and `err_miss_o` high. A pulse edge in the same fast cycle as that sample-clock edge does not count for the old period.
- R9: Pulse edges before the first sample-clock edge after reset produce no sample.
- R10: `sample_o`, `err_miss_o` and `err_sum_o` hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_clk_i | input | 1 | Sample clock; its rising edge starts a period |
| pos_dly_i | input | 1 | Output of the positive delay chain |
| neg_dly_i | input | 1 | Output of the negative delay chain |
| cfg_recip_i | input | RECIP_W | Reciprocal of the slope constant, scaled by 2^SHIFT |
| cfg_ofs_diff_i | input | CNT_W+1 | Signed offset-constant difference, in code units |
| cfg_sum_i | input | CNT_W+1 | Expected DP + DN |
| cfg_tol_i | input | CNT_W | Allowed deviation of DP + DN |
| sample_o | output | OUT_W | Recovered signed sample |
| valid_o | output | 1 | One-cycle strobe for a new sample |
| err_miss_o | output | 1 | A pulse edge was missing in the period |
| err_sum_o | output | 1 | DP + DN is outside tolerance |

## Verification
Two things can land on the same fast cycle: the pulse edge that would close the current period, and the sample-clock edge that opens the next one. The bench provokes this by driving the negative pulse on the same cycle as the next sample-clock rise. The old period must then come out with the missing code and `err_miss_o` high, and the new period must still measure its own codes correctly. The counter reaching its limit while a period is still open is exercised as a separate case, with a long period and a dropped pulse.

// File: rtl/ddtdc_pkg.sv
package ddtdc_pkg;
  typedef enum int unsigned {
    CH_SMP = 0,
    CH_POS = 1,
    CH_NEG = 2
  } chan_e;
  localparam int unsigned NUM_CH = 3;
endpackage

// File: rtl/ddtdc_edge_sync.sv
module ddtdc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R2
  rise_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ddtdc_frame_ctrl.sv
module ddtdc_frame_ctrl #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_rise_i,
  input  logic             p_rise_i,
  input  logic             n_rise_i,
  output logic             fire_o,
  output logic [CNT_W-1:0] dp_o,
  output logic [CNT_W-1:0] dn_o,
  output logic             mp_o,
  output logic             mn_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             active_q, active_d, done_q, done_d;
  logic             got_p_q, got_p_d, got_n_q, got_n_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, dp_q, dp_d, dn_q, dn_d;
  logic             p_hit, n_hit, p_now, n_now;

  always_comb begin
    active_d = active_q;
    done_d   = done_q;
    got_p_d  = got_p_q;
    got_n_d  = got_n_q;
    cnt_d    = cnt_q;
    dp_d     = dp_q;
    dn_d     = dn_q;
    fire_o   = 1'b0;
    p_hit    = p_rise_i & ~got_p_q;
    n_hit    = n_rise_i & ~got_n_q;
    p_now    = got_p_q | p_hit;
    n_now    = got_n_q | n_hit;
    dp_o     = got_p_q ? dp_q : CNT_MAX;
    dn_o     = got_n_q ? dn_q : CNT_MAX;
    mp_o     = ~got_p_q;
    mn_o     = ~got_n_q;
    if (smp_rise_i) begin
      fire_o   = active_q & ~done_q;
      active_d = 1'b1;
      done_d   = 1'b0;
      got_p_d  = 1'b0;
      got_n_d  = 1'b0;
      cnt_d    = CNT_ONE;
    end else if (active_q && !done_q) begin
      if (p_hit) begin
        dp_o    = cnt_q;
        dp_d    = cnt_q;
        got_p_d = 1'b1;
      end
      if (n_hit) begin
        dn_o    = cnt_q;
        dn_d    = cnt_q;
        got_n_d = 1'b1;
      end
      mp_o = ~p_now;
      mn_o = ~n_now;
      if ((p_now && n_now) || (cnt_q == CNT_MAX)) begin
        fire_o = 1'b1;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      got_p_q  <= 1'b0;
      got_n_q  <= 1'b0;
      cnt_q    <= '0;
      dp_q     <= '0;
      dn_q     <= '0;
    end else begin
      active_q <= active_d;
      done_q   <= done_d;
      got_p_q  <= got_p_d;
      got_n_q  <= got_n_d;
      cnt_q    <= cnt_d;
      dp_q     <= dp_d;
      dn_q     <= dn_d;
    end
  end

  // R8
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_rise_i |=> (cnt_q == CNT_ONE) && !done_q && !got_p_q && !got_n_q);
  // R4
  one_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);
  // R7
  sat_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && !smp_rise_i && (mp_o || mn_o)) |-> (cnt_q == CNT_MAX));
endmodule

// File: rtl/ddtdc_recon.sv
module ddtdc_recon #(
  parameter int unsigned CNT_W   = 10,
  parameter int unsigned RECIP_W = 16,
  parameter int unsigned SHIFT   = 12,
  localparam int unsigned NUM_W  = CNT_W + 2,
  localparam int unsigned PROD_W = NUM_W + RECIP_W + 1,
  localparam int unsigned OUT_W  = PROD_W - SHIFT - 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    fire_i,
  input  logic [CNT_W-1:0]        dp_i,
  input  logic [CNT_W-1:0]        dn_i,
  input  logic                    mp_i,
  input  logic                    mn_i,
  input  logic [RECIP_W-1:0]      cfg_recip_i,
  input  logic signed [CNT_W:0]   cfg_ofs_diff_i,
  input  logic [CNT_W:0]          cfg_sum_i,
  input  logic [CNT_W-1:0]        cfg_tol_i,
  output logic                    valid_o,
  output logic signed [OUT_W-1:0] sample_o,
  output logic                    err_miss_o,
  output logic                    err_sum_o
);
  // stage A: captured codes
  logic             a_v_q, a_mp_q, a_mn_q;
  logic [CNT_W-1:0] a_dp_q, a_dn_q;
  // stage B: difference and sum check
  logic                    b_v_q, b_miss_q, b_serr_q;
  logic signed [NUM_W-1:0] b_num_q;
  // stage C: outputs
  logic                    c_v_q, c_miss_q, c_serr_q;
  logic signed [OUT_W-1:0] c_smp_q;

  logic [CNT_W:0]           sum_w;
  logic signed [NUM_W-1:0]  dev_w, num_w;
  logic [NUM_W-1:0]         abs_w;
  logic                     serr_w;
  logic signed [PROD_W-1:0] prod_w;
  logic signed [OUT_W-1:0]  smp_w;

  always_comb begin
    sum_w  = {1'b0, a_dp_q} + {1'b0, a_dn_q};
    dev_w  = $signed({1'b0, sum_w}) - $signed({1'b0, cfg_sum_i});
    abs_w  = dev_w[NUM_W-1] ? $unsigned(-dev_w) : $unsigned(dev_w);
    serr_w = abs_w > {2'b00, cfg_tol_i};
    num_w  = $signed({2'b00, a_dp_q}) - $signed({2'b00, a_dn_q})
           - $signed({cfg_ofs_diff_i[CNT_W], cfg_ofs_diff_i});
    prod_w = b_num_q * $signed({1'b0, cfg_recip_i});
    smp_w  = OUT_W'(prod_w >>> (SHIFT + 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_v_q <= 1'b0; a_mp_q <= 1'b0; a_mn_q <= 1'b0;
      a_dp_q <= '0;  a_dn_q <= '0;
      b_v_q <= 1'b0; b_miss_q <= 1'b0; b_serr_q <= 1'b0; b_num_q <= '0;
      c_v_q <= 1'b0; c_miss_q <= 1'b0; c_serr_q <= 1'b0; c_smp_q <= '0;
    end else begin
      a_v_q <= fire_i;
      b_v_q <= a_v_q;
      c_v_q <= b_v_q;
      if (fire_i) begin
        a_dp_q <= dp_i;
        a_dn_q <= dn_i;
        a_mp_q <= mp_i;
        a_mn_q <= mn_i;
      end
      if (a_v_q) begin
        b_num_q  <= num_w;
        b_serr_q <= serr_w;
        b_miss_q <= a_mp_q | a_mn_q;
      end
      if (b_v_q) begin
        c_smp_q  <= smp_w;
        c_serr_q <= b_serr_q;
        c_miss_q <= b_miss_q;
      end
    end
  end

  assign valid_o    = c_v_q;
  assign sample_o   = c_smp_q;
  assign err_miss_o = c_miss_q;
  assign err_sum_o  = c_serr_q;

  // R7
  miss_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_v_q && a_mp_q) |-> (a_dp_q == '1));
  // R5
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(sample_o) && $stable(err_miss_o) && $stable(err_sum_o)));
endmodule

// File: rtl/ddtdc_top.sv
module ddtdc_top #(
  parameter int unsigned CNT_W   = 10,
  parameter int unsigned RECIP_W = 16,
  parameter int unsigned SHIFT   = 12,
  parameter int unsigned SYNC_N  = 2,
  localparam int unsigned OUT_W  = CNT_W + 2 + RECIP_W + 1 - SHIFT - 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    smp_clk_i,
  input  logic                    pos_dly_i,
  input  logic                    neg_dly_i,
  input  logic [RECIP_W-1:0]      cfg_recip_i,
  input  logic signed [CNT_W:0]   cfg_ofs_diff_i,
  input  logic [CNT_W:0]          cfg_sum_i,
  input  logic [CNT_W-1:0]        cfg_tol_i,
  output logic signed [OUT_W-1:0] sample_o,
  output logic                    valid_o,
  output logic                    err_miss_o,
  output logic                    err_sum_o
);
  import ddtdc_pkg::*;

  logic rst_meta_q, rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n      <= rst_meta_q;
    end
  end

  logic [NUM_CH-1:0] raw_vec, rise_vec;
  assign raw_vec[CH_SMP] = smp_clk_i;
  assign raw_vec[CH_POS] = pos_dly_i;
  assign raw_vec[CH_NEG] = neg_dly_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_sync
    ddtdc_edge_sync #(.STAGES(SYNC_N)) sync_i (
      .clk_i (clk_i),
      .rst_ni(rst_n),
      .d_i   (raw_vec[g]),
      .rise_o(rise_vec[g])
    );
  end

  logic             fire;
  logic [CNT_W-1:0] dp, dn;
  logic             mp, mn;

  ddtdc_frame_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .smp_rise_i(rise_vec[CH_SMP]),
    .p_rise_i  (rise_vec[CH_POS]),
    .n_rise_i  (rise_vec[CH_NEG]),
    .fire_o    (fire),
    .dp_o      (dp),
    .dn_o      (dn),
    .mp_o      (mp),
    .mn_o      (mn)
  );

  ddtdc_recon #(.CNT_W(CNT_W), .RECIP_W(RECIP_W), .SHIFT(SHIFT)) recon_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .fire_i        (fire),
    .dp_i          (dp),
    .dn_i          (dn),
    .mp_i          (mp),
    .mn_i          (mn),
    .cfg_recip_i   (cfg_recip_i),
    .cfg_ofs_diff_i(cfg_ofs_diff_i),
    .cfg_sum_i     (cfg_sum_i),
    .cfg_tol_i     (cfg_tol_i),
    .valid_o       (valid_o),
    .sample_o      (sample_o),
    .err_miss_o    (err_miss_o),
    .err_sum_o     (err_sum_o)
  );

  // R5
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    fire |-> ##3 valid_o);
  // R9
  first_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rise_vec[CH_SMP] && !$past(rst_n)) |-> !fire);
endmodule

// File: tb/ddtdc_tb_top.sv
module ddtdc_tb_top;
  localparam int CNT_W = 10;
  localparam int MAXC  = (1 << CNT_W) - 1;
  localparam int RECIP = 1365;
  localparam int OFSD  = 10;
  localparam int SUMX  = 400;
  localparam int TOL   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp = 1'b0, pos = 1'b0, neg = 1'b0;
  logic signed [15:0] sample;
  logic valid, emiss, esum;

  always #5 clk = ~clk;

  ddtdc_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .smp_clk_i(smp), .pos_dly_i(pos), .neg_dly_i(neg),
    .cfg_recip_i(16'(RECIP)), .cfg_ofs_diff_i(11'(OFSD)), .cfg_sum_i(11'(SUMX)),
    .cfg_tol_i(10'(TOL)), .sample_o(sample), .valid_o(valid),
    .err_miss_o(emiss), .err_sum_o(esum)
  );

  int total = 0, bad = 0, cyc = 0, vcount = 0;
  bit mon_on = 0, hold_pend = 0, pend = 0;
  int q_smp[$], q_miss[$], q_sum[$], q_cyc[$];
  int last_smp, last_miss, last_sum, pend_dp;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int dp, input int dn, input int miss, input int at);
    int num, s, dev;
    num = dp - dn - OFSD;
    s = (num * RECIP) >>> 13;
    dev = dp + dn - SUMX;
    if (dev < 0) dev = -dev;
    q_smp.push_back(s);
    q_miss.push_back(miss);
    q_sum.push_back(dev > TOL ? 1 : 0);
    q_cyc.push_back(at);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (hold_pend) begin
        hold_pend = 0;
        chk(int'(sample) == last_smp && int'(emiss) == last_miss && int'(esum) == last_sum,
            "R10 hold", int'(sample), last_smp);
      end
      if (valid) begin
        vcount++;
        if (q_smp.size() == 0) begin
          chk(1'b0, "R4 R9 unexpected strobe", int'(sample), 0);
        end else begin
          int es, em, ee, ec;
          es = q_smp.pop_front(); em = q_miss.pop_front();
          ee = q_sum.pop_front(); ec = q_cyc.pop_front();
          chk(int'(sample) == es, "R2 R3 sample", int'(sample), es);
          chk(int'(emiss) == em, "R7 R8 miss flag", int'(emiss), em);
          chk(int'(esum) == ee, "R6 sum flag", int'(esum), ee);
          chk(cyc == ec, "R5 latency", cyc, ec);
        end
        last_smp = int'(sample); last_miss = int'(emiss); last_sum = int'(esum);
        hold_pend = 1;
      end
    end
  end

  // driver: one sample-clock period; dn == period means neg edge lands on next smp edge
  task automatic run_frame(input int dp, input int dn, input int period,
                           input bit drop_n, input bit extra_p);
    @(negedge clk);
    smp = 1'b1; pos = 1'b0; neg = 1'b0;
    if (pend) begin
      neg = 1'b1;
      push(pend_dp, MAXC, 1, cyc + 5);
      pend = 0;
    end
    if (drop_n) push(dp, MAXC, 1, cyc + MAXC + 5);
    for (int i = 1; i < period; i++) begin
      @(negedge clk);
      smp = 1'b0;
      pos = (i == dp) || (extra_p && i == dp + 50);
      neg = !drop_n && (i == dn);
      if (!drop_n && dn < period && i == ((dp > dn) ? dp : dn))
        push(dp, dn, 0, cyc + 5);
    end
    if (!drop_n && dn >= period) begin
      pend = 1;
      pend_dp = dp;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(valid == 1'b0 && sample == 16'sd0 && !emiss && !esum, "R1 reset", int'(valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(valid == 1'b0 && sample == 16'sd0, "R1 after release", int'(sample), 0);
    mon_on = 1;
    // R9 pulses before first sample edge
    pos = 1'b1; neg = 1'b1;
    @(negedge clk);
    pos = 1'b0; neg = 1'b0;
    repeat (20) @(negedge clk);
    chk(vcount == 0, "R9 no strobe before first edge", vcount, 0);
    run_frame(250, 150, 420, 0, 0);   // R2 R3 positive
    run_frame(100, 300, 420, 0, 0);   // R3 negative
    run_frame(200, 204, 420, 0, 0);   // R6 at tolerance
    run_frame(200, 205, 420, 0, 0);   // R6 over tolerance
    run_frame(150, 150, 420, 0, 1);   // R4 equal edges, extra pulse
    run_frame(100, 0, 1040, 1, 0);    // R7 saturation
    run_frame(120, 300, 300, 0, 0);   // R8 collision with next edge
    run_frame(180, 220, 420, 0, 0);   // R8 next period still measured
    run_frame(330, 70, 420, 0, 0);    // R3 large positive
    repeat (20) @(negedge clk);
    chk(q_smp.size() == 0, "R4 all samples emitted", q_smp.size(), 0);
    chk(vcount == 9, "R4 one strobe per period", vcount, 9);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule